// File: doc/BRIEF.md
# UART automatic baud-rate detector

This block finds the bit rate of a host's asynchronous serial link without being told it. After a start strobe it watches the synchronized receive line and counts system-clock cycles across the low run that one 0x00 byte produces. That run lasts nine bit times: the start bit and eight zero data bits. It divides the count by nine, rounding to the nearest integer, to get a bit-period divisor. It then checks the divisor against tolerance windows around the nominal divisors for 4800, 9600 and 19200 bps at the configured clock frequency.

An accepted divisor starts a short confirmation exchange. The block sends one 0x00 byte at the detected rate and then waits for the host to answer with 0x55. Only an error-free 0x55 locks the block. A locked block then presents the divisor and holds it until reset. Every failure raises the error flag and returns the block to idle. The host then repeats the whole procedure. Framing is always 8 data bits, 1 stop bit and no parity, least significant bit first.

Top module: `autobaud_top`

## Requirements
- R1: In reset and straight after it, `txd_o` is high, `locked_o` and `error_o` are low and `divisor_o` is zero.
- R2: After an accepted start, the block counts the cycles L from the first falling edge of the synchronized receive line to the next rising edge. The candidate divisor is floor((L+4)/9), which is L/9 rounded with halves going up.
- R3: For r in {4800, 9600, 19200}, N = floor((CLK_HZ + r/2)/r) and S = floor(N*TOL_PCT/100). A candidate is accepted only if it lies in [N-S, N+S] for some r. Otherwise `error_o` rises, the block returns to idle and `txd_o` never goes low.
- R4: If the low run lasts 2^CNT_W-1 cycles and the line is still low, `error_o` rises and the block returns to idle without transmitting.
- R5: After acceptance, `txd_o` carries one 0x00 frame at the candidate period: nine low bit times (start bit and eight zero data bits), then a high stop bit. Outside that frame `txd_o` stays high.
- R6: After the frame, the block receives one byte, sampling each bit near mid-period with the candidate. If the byte is 0x55 with a high stop bit, `locked_o` rises one cycle after reception and `divisor_o` shows the candidate.
- R7: A received byte other than 0x55 raises `error_o` and leaves `locked_o` low.
- R8: A 0x55 received with a low stop bit raises `error_o` and leaves `locked_o` low.
- R9: Once locked, the block ignores `start_i` and `rxd_i`. `locked_o` stays high, `divisor_o` holds its value and `txd_o` stays high until reset.
- R10: `error_o` stays high while the block is idle and clears in the cycle after the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that arms a detection while idle |
| rxd_i | input | 1 | Serial receive line from the host, idle high |
| txd_o | output | 1 | Serial transmit line to the host, idle high |
| divisor_o | output | DIV_W | Detected bit period in clock cycles, zero until locked |
| locked_o | output | 1 | Detection confirmed by the handshake |
| error_o | output | 1 | Last detection attempt failed |

## Verification
The bench builds the block with CLK_HZ = 192000, TOL_PCT = 4 and CNT_W = 10. This gives nominal divisors of 40, 20 and 10 and windows [39,41], [20,20] and [10,10]. At that size every bit period from 6 to 44 cycles can be swept. The sweep reaches both edges of each window and the gaps between them, and each accepted period goes through the full handshake. Low runs of 175, 176, 184 and 185 cycles straddle the rounding boundaries around a divisor of 20. The 10-bit counter brings saturation within about a thousand cycles.

// File: rtl/ab_pkg.sv
package ab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEAS,
        ST_DIV,
        ST_SEND,
        ST_ACK,
        ST_LOCK
    } ab_state_e;

    typedef enum logic [1:0] {
        LT_OFF,
        LT_WAIT,
        LT_RUN
    } lt_state_e;

    typedef enum logic [2:0] {
        RX_OFF,
        RX_HUNT,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/ab_lowtimer.sv
module ab_lowtimer
    import ab_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_i,
    input  logic             arm_i,
    output logic             rx_s_o,
    output logic             done_o,
    output logic             sat_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [2:0]       sync;
        lt_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             sat;
    } lt_s;

    lt_s r_q, r_d;
    logic rx_s, rx_prev;

    assign rx_s    = r_q.sync[1];
    assign rx_prev = r_q.sync[2];

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[1:0], rxd_i};
        r_d.done = 1'b0;
        r_d.sat  = 1'b0;
        case (r_q.st)
            LT_OFF: begin
                if (arm_i) r_d.st = LT_WAIT;
            end
            LT_WAIT: begin
                if (rx_prev && !rx_s) begin
                    r_d.st  = LT_RUN;
                    r_d.cnt = CNT_W'(1);
                end
            end
            LT_RUN: begin
                if (rx_s) begin
                    r_d.done = 1'b1;
                    r_d.st   = LT_OFF;
                end else if (&r_q.cnt) begin
                    r_d.sat = 1'b1;
                    r_d.st  = LT_OFF;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.st = LT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sync: 3'b111, st: LT_OFF, cnt: '0, done: 1'b0, sat: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_s_o = rx_s;
    assign done_o = r_q.done;
    assign sat_o  = r_q.sat;
    assign cnt_o  = r_q.cnt;

    AST_SAT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (&cnt_o)); // R4
    AST_RUN_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rx_prev && cnt_o != '0)); // R2

endmodule

// File: rtl/ab_div9.sv
module ab_div9 #(
    parameter int CNT_W = 16,
    parameter int DIV_W = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             done_o,
    output logic [DIV_W-1:0] q_o
);

    localparam int REM_W = CNT_W + 1;

    typedef struct packed {
        logic             busy;
        logic [REM_W-1:0] rem;
        logic [DIV_W-1:0] q;
        logic             done;
    } dv_s;

    dv_s r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (go_i) begin
            r_d.busy = 1'b1;
            r_d.rem  = REM_W'(cnt_i) + REM_W'(4);
            r_d.q    = '0;
        end else if (r_q.busy) begin
            if (r_q.rem >= REM_W'(9)) begin
                r_d.rem = r_q.rem - REM_W'(9);
                r_d.q   = r_q.q + DIV_W'(1);
            end else begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = r_q.done;
    assign q_o    = r_q.q;

    AST_REM_BELOW_NINE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (r_q.rem < REM_W'(9))); // R2
    AST_QUOT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && !go_i && r_q.rem >= REM_W'(9)) |-> !(&r_q.q)); // R2

endmodule

// File: rtl/ab_tx.sv
module ab_tx #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [7:0]       data_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             txd_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        logic             busy;
        logic [9:0]       frame;
        logic [3:0]       bitn;
        logic [DIV_W-1:0] cnt;
        logic             done;
    } tx_s;

    tx_s r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (go_i) begin
                r_d.busy  = 1'b1;
                r_d.frame = {1'b1, data_i, 1'b0};
                r_d.bitn  = '0;
                r_d.cnt   = '0;
            end
        end else if (r_q.cnt == div_i - DIV_W'(1)) begin
            r_d.cnt = '0;
            if (r_q.bitn == 4'd9) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.bitn  = r_q.bitn + 4'd1;
                r_d.frame = {1'b1, r_q.frame[9:1]};
            end
        end else begin
            r_d.cnt = r_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{busy: 1'b0, frame: '1, bitn: '0, cnt: '0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign txd_o  = r_q.busy ? r_q.frame[0] : 1'b1;
    assign busy_o = r_q.busy;
    assign done_o = r_q.done;

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o) |=> !txd_o); // R5
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o); // R5

endmodule

// File: rtl/ab_rx.sv
module ab_rx
    import ab_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             rx_s_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             done_o,
    output logic             ok_o,
    output logic [7:0]       data_o
);

    typedef struct packed {
        rx_state_e        st;
        logic             prev;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic             done;
        logic             ok;
    } rx_s;

    rx_s r_q, r_d;
    logic [DIV_W-1:0] half;

    assign half = div_i >> 1;

    always_comb begin
        r_d      = r_q;
        r_d.prev = rx_s_i;
        r_d.done = 1'b0;
        case (r_q.st)
            RX_OFF: begin
                if (go_i) r_d.st = RX_HUNT;
            end
            RX_HUNT: begin
                if (r_q.prev && !rx_s_i) begin
                    r_d.st  = RX_START;
                    r_d.cnt = '0;
                end
            end
            RX_START: begin
                if (r_q.cnt == half) begin
                    r_d.cnt  = '0;
                    r_d.bitn = '0;
                    r_d.st   = rx_s_i ? RX_HUNT : RX_BITS;
                end else begin
                    r_d.cnt = r_q.cnt + DIV_W'(1);
                end
            end
            RX_BITS: begin
                if (r_q.cnt == div_i - DIV_W'(1)) begin
                    r_d.cnt = '0;
                    r_d.sh  = {rx_s_i, r_q.sh[7:1]};
                    if (r_q.bitn == 3'd7) r_d.st = RX_STOP;
                    else                  r_d.bitn = r_q.bitn + 3'd1;
                end else begin
                    r_d.cnt = r_q.cnt + DIV_W'(1);
                end
            end
            RX_STOP: begin
                if (r_q.cnt == div_i - DIV_W'(1)) begin
                    r_d.done = 1'b1;
                    r_d.ok   = rx_s_i;
                    r_d.st   = RX_OFF;
                end else begin
                    r_d.cnt = r_q.cnt + DIV_W'(1);
                end
            end
            default: r_d.st = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RX_OFF, prev: 1'b1, cnt: '0, bitn: '0, sh: '0, done: 1'b0, ok: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign ok_o   = r_q.ok;
    assign data_o = r_q.sh;

    AST_RX_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

endmodule

// File: rtl/autobaud_top.sv
module autobaud_top
    import ab_pkg::*;
#(
    parameter int CLK_HZ  = 20_000_000,
    parameter int TOL_PCT = 4,
    parameter int CNT_W   = 16,
    parameter int DIV_W   = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rxd_i,
    output logic             txd_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             locked_o,
    output logic             error_o
);

    localparam int NRATE     = 3;
    localparam int BASE_RATE = 4800;

    typedef struct packed {
        ab_state_e        st;
        logic [DIV_W-1:0] cand;
        logic [DIV_W-1:0] div;
        logic             locked;
        logic             err;
    } top_s;

    top_s r_q, r_d;

    logic             arm, dv_go, tx_go, rx_go;
    logic             rx_s, lt_done, lt_sat;
    logic [CNT_W-1:0] lt_cnt;
    logic             dv_done;
    logic [DIV_W-1:0] dv_q;
    logic             tx_busy, tx_done;
    logic             rx_done, rx_ok;
    logic [7:0]       rx_data;
    logic [NRATE-1:0] win;

    ab_lowtimer #(.CNT_W(CNT_W)) lowtimer_i (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .arm_i(arm),
        .rx_s_o(rx_s), .done_o(lt_done), .sat_o(lt_sat), .cnt_o(lt_cnt)
    );

    ab_div9 #(.CNT_W(CNT_W), .DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .go_i(dv_go), .cnt_i(lt_cnt),
        .done_o(dv_done), .q_o(dv_q)
    );

    ab_tx #(.DIV_W(DIV_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .go_i(tx_go), .data_i(8'h00), .div_i(r_q.cand),
        .txd_o(txd_o), .busy_o(tx_busy), .done_o(tx_done)
    );

    ab_rx #(.DIV_W(DIV_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .go_i(rx_go), .rx_s_i(rx_s), .div_i(r_q.cand),
        .done_o(rx_done), .ok_o(rx_ok), .data_o(rx_data)
    );

    for (genvar g = 0; g < NRATE; g++) begin : g_win
        localparam int RATE  = BASE_RATE << g;
        localparam int NOM   = (CLK_HZ + RATE / 2) / RATE;
        localparam int SLACK = NOM * TOL_PCT / 100;
        assign win[g] = (dv_q >= DIV_W'(NOM - SLACK)) && (dv_q <= DIV_W'(NOM + SLACK));
    end

    always_comb begin
        r_d   = r_q;
        arm   = 1'b0;
        dv_go = 1'b0;
        tx_go = 1'b0;
        rx_go = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.err = 1'b0;
                    r_d.st  = ST_MEAS;
                    arm     = 1'b1;
                end
            end
            ST_MEAS: begin
                if (lt_sat) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (lt_done) begin
                    dv_go  = 1'b1;
                    r_d.st = ST_DIV;
                end
            end
            ST_DIV: begin
                if (dv_done) begin
                    if (|win) begin
                        r_d.cand = dv_q;
                        r_d.st   = ST_SEND;
                        tx_go    = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            ST_SEND: begin
                if (tx_done) begin
                    r_d.st = ST_ACK;
                    rx_go  = 1'b1;
                end
            end
            ST_ACK: begin
                if (rx_done) begin
                    if (rx_ok && rx_data == 8'h55) begin
                        r_d.locked = 1'b1;
                        r_d.div    = r_q.cand;
                        r_d.st     = ST_LOCK;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end
                end
            end
            ST_LOCK: begin
                r_d.st = ST_LOCK;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cand: '0, div: '0, locked: 1'b0, err: 1'b0};
        else        r_q <= r_d;
    end

    assign divisor_o = r_q.div;
    assign locked_o  = r_q.locked;
    assign error_o   = r_q.err;

    AST_LOCK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && error_o)); // R3
    AST_LOCK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK && rx_done && rx_ok && rx_data == 8'h55) |=> locked_o); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o); // R9
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> $stable(divisor_o)); // R9
    AST_DIV_ZERO_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> (divisor_o == '0)); // R6
    AST_TXD_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_SEND) |-> (txd_o && !tx_busy)); // R5
    AST_SAT_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MEAS && lt_sat) |=> (error_o && r_q.st == ST_IDLE)); // R4

endmodule

// File: tb/autobaud_top_tb_top.sv
`timescale 1ns/1ps
module autobaud_top_tb_top;

    localparam int CLK_HZ = 192000;
    localparam int TOL    = 4;
    localparam int CNT_W  = 10;
    localparam int DIV_W  = CNT_W - 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rxd = 1'b1;
    logic             txd;
    logic [DIV_W-1:0] divisor;
    logic             locked;
    logic             err;

    int  total = 0;
    int  bad = 0;
    int  tx_falls = 0;
    bit  finished = 0;
    logic txd_prev = 1'b1;

    always #2.5 clk = ~clk;

    autobaud_top #(.CLK_HZ(CLK_HZ), .TOL_PCT(TOL), .CNT_W(CNT_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rxd_i(rxd),
        .txd_o(txd), .divisor_o(divisor), .locked_o(locked), .error_o(err)
    );

    always @(negedge clk) begin
        if (txd_prev && !txd) tx_falls = tx_falls + 1;
        txd_prev = txd;
    end

    function automatic int exp_div(int len);
        return (len + 4) / 9;
    endfunction

    function automatic bit exp_win(int d);
        for (int g = 0; g < 3; g++) begin
            int rate = 4800 << g;
            int nom  = (CLK_HZ + rate / 2) / rate;
            int sl   = nom * TOL / 100;
            if (d >= nom - sl && d <= nom + sl) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rxd   = 1'b1;
        start = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_low(int len);
        rxd = 1'b0;
        wait_cyc(len);
        rxd = 1'b1;
    endtask

    task automatic send_byte(logic [7:0] b, int p, logic stopv);
        rxd = 1'b0;
        wait_cyc(p);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_cyc(p);
        end
        rxd = stopv;
        wait_cyc(p);
        rxd = 1'b1;
    endtask

    // R5: expect nine low bit times then a high stop bit at period p
    task automatic check_tx(int p);
        int waited = 0;
        while (txd && waited < 40 * p) begin
            @(negedge clk);
            waited++;
        end
        chk("R5 tx frame started", int'(txd), 0);
        wait_cyc(p / 2);
        for (int i = 0; i < 10; i++) begin
            chk("R5 tx bit", int'(txd), (i < 9) ? 0 : 1);
            wait_cyc(p);
        end
    endtask

    task automatic attempt(int len, logic [7:0] resp, logic stopv);
        int d;
        int f0;
        do_reset();
        pulse_start();
        wait_cyc(3);
        f0 = tx_falls;
        send_low(len);
        d = exp_div(len);
        if (exp_win(d)) begin
            check_tx(d);
            send_byte(resp, d, stopv);
            wait_cyc(6);
            if (resp == 8'h55 && stopv) begin
                chk("R6 locked after 0x55", int'(locked), 1);
                chk("R2 divisor value", int'(divisor), d);
                chk("R6 no error", int'(err), 0);
            end else if (resp != 8'h55) begin
                chk("R7 wrong byte error", int'(err), 1);
                chk("R7 wrong byte not locked", int'(locked), 0);
            end else begin
                chk("R8 bad stop error", int'(err), 1);
                chk("R8 bad stop not locked", int'(locked), 0);
            end
        end else begin
            wait_cyc(d + 40);
            chk("R3 out of window error", int'(err), 1);
            chk("R3 out of window not locked", int'(locked), 0);
            chk("R3 no transmission", tx_falls - f0, 0);
        end
    endtask

    initial begin
        int f0;
        // R1: reset state
        rst_n = 1'b0;
        wait_cyc(3);
        chk("R1 txd idle in reset", int'(txd), 1);
        chk("R1 locked low in reset", int'(locked), 0);
        chk("R1 error low in reset", int'(err), 0);
        chk("R1 divisor zero in reset", int'(divisor), 0);
        do_reset();
        chk("R1 txd idle after reset", int'(txd), 1);
        chk("R1 divisor zero after reset", int'(divisor), 0);

        // R2 R3 R5 R6: sweep of every bit period across and between the windows
        for (int p = 6; p <= 44; p++) attempt(9 * p, 8'h55, 1'b1);

        // R2: rounding boundaries around a divisor of 20
        attempt(176, 8'h55, 1'b1);
        attempt(184, 8'h55, 1'b1);
        attempt(175, 8'h55, 1'b1);
        attempt(185, 8'h55, 1'b1);

        // R7: wrong reply bytes
        attempt(180, 8'h54, 1'b1);
        attempt(360, 8'hD5, 1'b1);
        // R8: correct reply with a low stop bit
        attempt(360, 8'h55, 1'b0);

        // R4: saturation of the low-period counter
        do_reset();
        pulse_start();
        wait_cyc(3);
        f0 = tx_falls;
        send_low(1100);
        wait_cyc(40);
        chk("R4 saturation error", int'(err), 1);
        chk("R4 saturation not locked", int'(locked), 0);
        chk("R4 no transmission", tx_falls - f0, 0);

        // R10: error held while idle, cleared by next start
        wait_cyc(20);
        chk("R10 error held", int'(err), 1);
        pulse_start();
        chk("R10 error cleared by start", int'(err), 0);

        // R9: after lock, start and rxd are ignored
        attempt(180, 8'h55, 1'b1);
        f0 = tx_falls;
        pulse_start();
        wait_cyc(3);
        send_low(90);
        wait_cyc(20);
        send_byte(8'h55, 10, 1'b1);
        wait_cyc(50);
        chk("R9 locked held", int'(locked), 1);
        chk("R9 divisor held", int'(divisor), 20);
        chk("R9 no transmission", tx_falls - f0, 0);
        chk("R9 no error", int'(err), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule